// File: doc/BRIEF.md
# Windowed Self-Clocked Serial Result Port

This block is the serial output stage of a converter that makes one result per frame. A frame counter runs on the master clock. At each frame boundary the block copies the most recent result from a staging register into the port register. It signals this with an active-low ready flag. A host asks for the word by pulling an active-low select low. The select is only examined at eight fixed sample points spread across each frame.

When a sample point grants a request, the block shifts the port word out, most significant bit first. It generates its own serial clock at a quarter of the master clock rate. Both the serial clock and the serial data have an output enable, so a board-level tri-state driver can float them. Releasing the select in the middle of a word ends the transfer at the next bit boundary. The same word is then still available in a later window.

A grant in the last window of a frame runs past the frame boundary. In that case the refresh at that boundary is skipped, and the port keeps its word until the boundary after.

Top module: `winser_port`

## Requirements
- R1: A frame is 1024 master-clock cycles. The cycle in which `rdy_n` goes low is frame cycle 1. With no transfer taking place, `rdy_n` stays low through frame cycle 1020, is high for frame cycles 1021 to 1024, and goes low again on the next frame cycle 1.
- R2: `cs_n` is examined only on frame cycles 76 + 128·k, for k = 0..7. When a request is granted, `sdo_oe` and `sclk_oe` go high on the next cycle.
- R3: A request is granted only if `cs_n` is low on the sample cycle and also on each of the three cycles before it. If `cs_n` has been low for fewer cycles, that window sends nothing.
- R4: Each bit lasts 4 master cycles. `sclk_o` is low for the first 2 of them and high for the last 2. `sdo` holds its value while `sclk_o` is high. Bits are sent MSB first.
- R5: After the last bit, both enables drop and `rdy_n` goes high, even if `cs_n` is still low.
- R6: If `cs_n` goes high during a bit, that bit runs to the end of its 4 cycles. Both outputs are then disabled. `rdy_n` stays low, and the untouched word can be requested again in a later window.
- R7: A transfer granted in the eighth window is still in progress at the frame boundary. That boundary's refresh is skipped. `rdy_n` goes high when the transfer ends and falls again only at the following boundary.
- R8: A `new_vld` pulse captures `new_data` into the staging register. The port word changes only at an idle frame boundary, so a capture during a transfer does not alter the bits being sent.
- R9: While reset is held, `rdy_n` is high and both enables are low. The first clock edge after reset is released is a frame boundary, so `rdy_n` is low in the cycle after it.
- R10: Once a word has been sent in full, later windows of the same frame grant nothing, even with `cs_n` held low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low request/select from host |
| new_vld | input | 1 | Strobe: new result present on new_data |
| new_data | input | WORD_W | Result word from the filter |
| rdy_n | output | 1 | Active-low fresh-word flag |
| sclk_o | output | 1 | Generated serial clock value |
| sclk_oe | output | 1 | Serial clock output enable |
| sdo | output | 1 | Serial data value |
| sdo_oe | output | 1 | Serial data output enable |

## Verification
The frame-boundary refresh and a shift in progress can both fall on the same cycle. This only happens when the eighth window is granted, because the word then runs across the boundary. The bench sets this up by asserting the select three cycles before the last sample point. It also loads a second result into staging just before the grant. It then checks three things: the bits received are the first word, the ready flag does not fall at the boundary and goes high after the last bit, and the second word appears only one whole frame later.

// File: rtl/winser_pkg.sv
package winser_pkg;
    typedef enum logic [0:0] {
        SH_IDLE = 1'b0,
        SH_RUN  = 1'b1
    } sh_state_e;
endpackage

// File: rtl/winser_frame_timer.sv
module winser_frame_timer #(
    parameter int FRAME_LEN = 1024,
    parameter int FIRST_WIN = 75,
    parameter int WIN_STEP  = 128,
    parameter int NUM_WIN   = 8,
    parameter int TAIL_LEN  = 4,
    localparam int CW       = $clog2(FRAME_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] cnt_o,
    output logic          win_o,
    output logic          upd_o,
    output logic          tail_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } tm_t;

    tm_t tm_d, tm_q;
    logic [NUM_WIN-1:0] hit;

    generate
        for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
            assign hit[g] = (tm_q.cnt == CW'(FIRST_WIN + g * WIN_STEP));
        end
    endgenerate

    always_comb begin
        tm_d = tm_q;
        if (tm_q.cnt == CW'(FRAME_LEN - 1)) tm_d.cnt = '0;
        else                                tm_d.cnt = tm_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q.cnt <= CW'(FRAME_LEN - 1);
        else        tm_q     <= tm_d;
    end

    assign cnt_o  = tm_q.cnt;
    assign win_o  = |hit;
    assign upd_o  = (tm_q.cnt == CW'(FRAME_LEN - 1));
    assign tail_o = (tm_q.cnt >= CW'(FRAME_LEN - TAIL_LEN));
endmodule

// File: rtl/winser_cs_qual.sv
module winser_cs_qual #(
    parameter int CS_SETUP = 3,
    localparam int RW      = $clog2(CS_SETUP + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic win_i,
    output logic grant_o
);
    typedef struct packed {
        logic [RW-1:0] run;
    } cq_t;

    cq_t cq_d, cq_q;

    always_comb begin
        cq_d = cq_q;
        if (cs_n)                              cq_d.run = '0;
        else if (cq_q.run != RW'(CS_SETUP))    cq_d.run = cq_q.run + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cq_q.run <= '0;
        else        cq_q     <= cq_d;
    end

    assign grant_o = win_i && !cs_n && (cq_q.run >= RW'(CS_SETUP));

    // R3: a grant needs the select already low on the previous edge
    assert_grant_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> !$past(cs_n));
endmodule

// File: rtl/winser_shifter.sv
module winser_shifter
    import winser_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DIV    = 4,
    localparam int IW    = $clog2(WORD_W),
    localparam int PW    = $clog2(DIV)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              new_vld,
    input  logic [WORD_W-1:0] new_data,
    input  logic              upd_i,
    input  logic              grant_i,
    input  logic              cs_n,
    output logic              busy_o,
    output logic              fresh_o,
    output logic              sclk_o,
    output logic              sdo_o
);
    typedef struct packed {
        logic [WORD_W-1:0] stage;
        logic [WORD_W-1:0] word;
        logic              fresh;
        sh_state_e         state;
        logic [IW-1:0]     idx;
        logic [PW-1:0]     ph;
        logic              abort;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (new_vld) sh_d.stage = new_data;
        case (sh_q.state)
            SH_IDLE: begin
                if (upd_i) begin
                    sh_d.word  = sh_q.stage;
                    sh_d.fresh = 1'b1;
                end else if (grant_i && sh_q.fresh) begin
                    sh_d.state = SH_RUN;
                    sh_d.idx   = IW'(WORD_W - 1);
                    sh_d.ph    = '0;
                    sh_d.abort = 1'b0;
                end
            end
            SH_RUN: begin
                if (cs_n) sh_d.abort = 1'b1;
                if (sh_q.ph == PW'(DIV - 1)) begin
                    sh_d.ph = '0;
                    if (sh_q.idx == '0) begin
                        sh_d.state = SH_IDLE;
                        sh_d.fresh = 1'b0;
                    end else if (sh_q.abort || cs_n) begin
                        sh_d.state = SH_IDLE;
                    end else begin
                        sh_d.idx = sh_q.idx - 1'b1;
                    end
                end else begin
                    sh_d.ph = sh_q.ph + 1'b1;
                end
            end
            default: sh_d.state = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q.stage <= '0;
            sh_q.word  <= '0;
            sh_q.fresh <= 1'b0;
            sh_q.state <= SH_IDLE;
            sh_q.idx   <= '0;
            sh_q.ph    <= '0;
            sh_q.abort <= 1'b0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign busy_o  = (sh_q.state == SH_RUN);
    assign fresh_o = sh_q.fresh;
    assign sclk_o  = busy_o && (sh_q.ph >= PW'(DIV / 2));
    assign sdo_o   = busy_o && sh_q.word[sh_q.idx];

    // R4: data may only move while the serial clock is low
    assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(sdo_o));

    // R7: a boundary reached mid-transfer leaves the port word untouched
    assert_skip_refresh_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && busy_o) |=> $stable(sh_q.word));
endmodule

// File: rtl/winser_port.sv
module winser_port #(
    parameter int WORD_W    = 16,
    parameter int FRAME_LEN = 1024,
    parameter int FIRST_WIN = 75,
    parameter int WIN_STEP  = 128,
    parameter int NUM_WIN   = 8,
    parameter int TAIL_LEN  = 4,
    parameter int CS_SETUP  = 3,
    parameter int DIV       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              new_vld,
    input  logic [WORD_W-1:0] new_data,
    output logic              rdy_n,
    output logic              sclk_o,
    output logic              sclk_oe,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int CW = $clog2(FRAME_LEN);

    logic [CW-1:0] frame_cnt;
    logic          win_hit, upd, tail, grant, busy, fresh;

    winser_frame_timer #(
        .FRAME_LEN(FRAME_LEN), .FIRST_WIN(FIRST_WIN), .WIN_STEP(WIN_STEP),
        .NUM_WIN(NUM_WIN), .TAIL_LEN(TAIL_LEN)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .cnt_o(frame_cnt),
        .win_o(win_hit), .upd_o(upd), .tail_o(tail)
    );

    winser_cs_qual #(.CS_SETUP(CS_SETUP)) u_qual (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .win_i(win_hit), .grant_o(grant)
    );

    winser_shifter #(.WORD_W(WORD_W), .DIV(DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .new_vld(new_vld), .new_data(new_data),
        .upd_i(upd), .grant_i(grant), .cs_n(cs_n), .busy_o(busy),
        .fresh_o(fresh), .sclk_o(sclk_o), .sdo_o(sdo)
    );

    assign rdy_n   = !(busy || (fresh && !tail));
    assign sclk_oe = busy;
    assign sdo_oe  = busy;

    // R1: the ready flag only ever falls on the first cycle of a frame
    assert_fall_frame_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_n) |-> (frame_cnt == '0));

    // R2: outputs are only enabled right after a sample point
    assert_start_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> $past(win_hit));

    // R6: outputs float only after a completed high clock phase
    assert_float_bit_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdo_oe) |-> $past(sclk_o));
endmodule

// File: tb/winser_port_bench.sv
module winser_port_bench;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic new_vld = 1'b0;
    logic [W-1:0] new_data = '0;
    logic rdy_n, sclk_o, sclk_oe, sdo, sdo_oe;

    always #4 clk = ~clk;

    winser_port #(.WORD_W(W)) u_winser_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .new_vld(new_vld),
        .new_data(new_data), .rdy_n(rdy_n), .sclk_o(sclk_o),
        .sclk_oe(sclk_oe), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    int pass_n = 0;
    int fail_n = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [W-1:0] word;
        int           win;
        int           lead;
        logic         grant;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{16'hA5C3, 0, 3, 1'b1},
        '{16'h8001, 3, 4, 1'b1},
        '{16'h7FFE, 5, 2, 1'b0},
        '{16'h1234, 6, 3, 1'b1},
        '{16'hFFFF, 2, 1, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        if (ok) pass_n++;
        else begin
            fail_n++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cyc++;
    endtask

    task automatic go_to(input int c);
        while (cyc < c) tick();
    endtask

    task automatic wait_fall();
        logic prev;
        do begin
            prev = rdy_n;
            @(negedge clk);
        end while (!(prev && !rdy_n));
        cyc = 0;
    endtask

    task automatic strobe(input logic [W-1:0] w);
        new_data = w;
        new_vld  = 1'b1;
        tick();
        new_vld  = 1'b0;
    endtask

    // receive a word whose first cycle with enables high is frame count st
    task automatic grab(input int st, output logic [W-1:0] got, output bit clk_ok);
        got = '0;
        clk_ok = 1'b1;
        for (int j = 0; j < W; j++) begin
            go_to(st + 4 * j + 1);
            if (!sdo_oe || !sclk_oe || sclk_o) clk_ok = 1'b0;
            got[W-1-j] = sdo;
            go_to(st + 4 * j + 2);
            if (!sclk_o || got[W-1-j] != sdo) clk_ok = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fail_n++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] got;
        bit ck;
        int ws;

        // R9: reset state
        repeat (3) @(negedge clk);
        chk(rdy_n == 1'b1, "R9", "rdy_n in reset", rdy_n, 1);
        chk(sdo_oe == 1'b0 && sclk_oe == 1'b0, "R9", "enables in reset", sdo_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rdy_n == 1'b0, "R9", "first boundary after reset", rdy_n, 0);

        // table of vectors, one frame each
        for (int v = 0; v < 5; v++) begin
            strobe(VEC[v].word);
            wait_fall();
            ws = 75 + 128 * VEC[v].win;
            go_to(ws - VEC[v].lead);
            cs_n = 1'b0;
            if (VEC[v].grant) begin
                grab(ws + 1, got, ck);
                chk(got == VEC[v].word, "R2", "word MSB first", int'(got), int'(VEC[v].word));
                chk(ck, "R4", "sclk phase and data hold", int'(ck), 1);
                go_to(ws + 1 + 4 * W);
                chk(!sdo_oe && rdy_n, "R5", "float and ready high after last bit",
                    int'({sdo_oe, rdy_n}), 1);
                go_to(ws + 128 + 1);
                chk(!sdo_oe && !sclk_oe, "R10", "no regrant next window", sdo_oe, 0);
                cs_n = 1'b1;
            end else begin
                go_to(ws + 1);
                chk(!sdo_oe && !sclk_oe, "R3", "short setup not granted", sdo_oe, 0);
                cs_n = 1'b1;
                go_to(1019);
                chk(rdy_n == 1'b0, "R1", "ready low at frame cycle 1020", rdy_n, 0);
                go_to(1020);
                chk(rdy_n == 1'b1, "R1", "ready high at frame cycle 1021", rdy_n, 1);
                go_to(1023);
                chk(rdy_n == 1'b1, "R1", "ready high at frame cycle 1024", rdy_n, 1);
                go_to(1024);
                chk(rdy_n == 1'b0, "R1", "ready falls after 1024 cycles", rdy_n, 0);
            end
        end

        // R6: select released during bit 2, word reread in window 1
        strobe(16'hC3A5);
        wait_fall();
        go_to(72);
        cs_n = 1'b0;
        go_to(85);
        cs_n = 1'b1;
        go_to(87);
        chk(sdo_oe == 1'b1, "R6", "bit finishes after release", sdo_oe, 1);
        go_to(88);
        chk(!sdo_oe && !sclk_oe, "R6", "float at bit boundary", sdo_oe, 0);
        chk(rdy_n == 1'b0, "R6", "word still fresh", rdy_n, 0);
        go_to(200);
        cs_n = 1'b0;
        grab(204, got, ck);
        chk(got == 16'hC3A5, "R6", "word resent whole", int'(got), 'hC3A5);
        cs_n = 1'b1;

        // R7 and R8: eighth window straddles the boundary
        strobe(16'h5AF0);
        wait_fall();
        go_to(968);
        cs_n = 1'b0;
        go_to(969);
        strobe(16'h0F0F);
        grab(972, got, ck);
        chk(got == 16'h5AF0, "R8", "staging does not disturb transfer", int'(got), 'h5AF0);
        chk(ck, "R7", "straddling transfer clocks", int'(ck), 1);
        go_to(1036);
        chk(!sdo_oe && rdy_n, "R7", "end of straddling word", int'({sdo_oe, rdy_n}), 1);
        go_to(1100);
        cs_n = 1'b1;
        chk(rdy_n == 1'b1, "R7", "no refresh this frame", rdy_n, 1);
        go_to(2047);
        chk(rdy_n == 1'b1, "R7", "ready high before next boundary", rdy_n, 1);
        go_to(2048);
        chk(rdy_n == 1'b0, "R7", "refresh at following boundary", rdy_n, 0);
        go_to(2048 + 72);
        cs_n = 1'b0;
        grab(2048 + 76, got, ck);
        chk(got == 16'h0F0F, "R8", "staged word loaded later", int'(got), 'h0F0F);
        cs_n = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
        $finish;
    end
endmodule